// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences a 10-bit successive-approximation conversion and steps one of eight analog channels through it. Time is measured in machine cycles. Each machine cycle ends on a clock where `mc_tick` is high. A conversion starts in one of two ways: software writes the start bit of the control register, or an enabled rising edge arrives on the external start pin.

A conversion lasts 50 machine cycles: two cycles to initialise, eight cycles of sampling with `sample_en` high, then four cycles for each result bit, working from the MSB down. The comparator and DAC sit outside the block. The block drives the trial code `dac_code` and reads the comparator's decision back on `cmp_in`. The upper eight result bits appear on `result_hi`. The lowest two bits sit in the top two bits of the readable control word.

The controller has five states:

- **IDLE** waits for an accepted start. It moves to INIT if the start arrives on a tick, and to ARM otherwise.
- **ARM** waits for the tick that ends the current machine cycle, then moves to INIT.
- **INIT** counts 2 ticks, then moves to SAMPLE.
- **SAMPLE** counts 8 ticks, then moves to RESOLVE.
- **RESOLVE** spends 4 ticks on each bit and returns to IDLE after the LSB.

From any state other than IDLE, `pwr_save` forces a return to IDLE, which aborts the conversion.

Top module: `sar_adc_sequencer`

## Requirements
- R1: After reset, the control word, `result_hi`, `chan_sel`, `dac_code` and `sample_en` are all zero.
- R2: The control word is laid out as follows. Bits 7:6 hold result bits 1:0. Bit 5 is the external-start enable, readable and writable. Bit 4 is the done flag. Bit 3 is the start/busy flag. Bits 2:0 are the channel. `result_hi` carries result bits 9:2.
- R3: A write with bit 3 set, when the start is accepted, makes busy read 1 on the clock after the write. The conversion then occupies the 50 machine cycles that follow the machine cycle of the write, so done sets on the 51st tick after the write.
- R4: When bit 5 is 1, a pin level sampled high at a tick after a low sample at the previous tick starts a conversion in the next machine cycle, so done sets 51 ticks after the pin rises. When bit 5 is 0, the pin has no effect.
- R5: `sample_en` is high for exactly 8 machine cycles, after 2 initialisation cycles. Each bit then takes 4 cycles, MSB first. `dac_code` is the bits resolved so far with the trial bit added, so the first trial is 0x200.
- R6: A trial bit is kept when `cmp_in` is 1 at the tick that ends its fourth cycle. With `cmp_in` = (input ≥ `dac_code`), the result equals the input code.
- R7: A start from software or from the pin is ignored and lost while busy is 1, while done is 1, or while `pwr_save` is 1.
- R8: Busy and done are never both 1, and busy clears on the clock that done sets. Writing 0 to bit 4 clears done, while writing 1 to it does not set it. Writing 0 to bit 3 does not clear busy.
- R9: The channel takes its new value from a write only when done and busy are both 0.
- R10: `pwr_save` during a conversion clears busy on the next clock, leaves done at 0 and leaves the result unchanged. A done flag and result already present are kept unchanged while `pwr_save` is high.
- R11: A single write that clears bit 4 and sets bit 3 while done is 1 starts a new conversion. The channel stays the same, whatever bits 2:0 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_tick | input | 1 | High on the clock that ends a machine cycle |
| reg_wr | input | 1 | Control-register write strobe |
| reg_wdata | input | 8 | Control-register write data |
| ext_start_pin | input | 1 | External start request, acting on a rising edge |
| cmp_in | input | 1 | Comparator decision: 1 when input ≥ `dac_code` |
| pwr_save | input | 1 | Idle or power-down indication |
| ctrl_rd | output | 8 | Control word as read back |
| result_hi | output | 8 | Result bits 9:2 |
| chan_sel | output | 3 | Analog multiplexer select |
| sample_en | output | 1 | High during the sampling window |
| dac_code | output | 10 | Trial code for the DAC |

## Verification
The bench builds the block with its default values: 10 result bits, 3 channel bits, and phases of 2, 8 and 4 machine cycles. It drives `mc_tick` once every three clocks. That makes the exact 51-tick latency from start to done measurable for both start sources, along with the 8-tick sampling window and the 0x200 first trial. A behavioural comparator, built from a fixed input code, lets the result be checked against that code, including at 0 and 0x3FF. Starts sent during busy, during done and during power saving, locked-channel writes, and an abort part-way through conversion are each observed at the ports.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_INIT,
        ST_SAMPLE,
        ST_RESOLVE
    } seq_state_e;

    // Control word bit positions (above the channel field)
    localparam int POS_BUSY = 3;
    localparam int POS_DONE = 4;
    localparam int POS_EXT  = 5;
endpackage

// File: rtl/sar_seq_edge.sv
module sar_seq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else if (tick) begin
            prev_q <= pin;
        end
    end

    assign rise = tick & pin & ~prev_q;
endmodule

// File: rtl/sar_seq_timer.sv
module sar_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    assign last = (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sar_seq_sar.sv
module sar_seq_sar #(
    parameter int RES = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           step,
    input  logic           cmp,
    output logic [RES-1:0] trial,
    output logic [RES-1:0] resolved,
    output logic           last_bit
);
    localparam int IDX_W = $clog2(RES);

    logic [RES-1:0]   acc_q;
    logic [IDX_W-1:0] idx_q;
    logic [RES-1:0]   probe;

    assign probe    = RES'(1) << idx_q;
    assign trial    = acc_q | probe;
    assign resolved = cmp ? trial : acc_q;
    assign last_bit = (idx_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            idx_q <= IDX_W'(RES - 1);
        end else if (clear) begin
            acc_q <= '0;
            idx_q <= IDX_W'(RES - 1);
        end else if (step) begin
            acc_q <= resolved;
            if (!last_bit) begin
                idx_q <= idx_q - IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/sar_adc_sequencer.sv
module sar_adc_sequencer
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int CH_BITS  = 3,
    parameter int INIT_CYC = 2,
    parameter int SAMP_CYC = 8,
    parameter int BIT_CYC  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mc_tick,
    input  logic                   reg_wr,
    input  logic [CH_BITS+4:0]     reg_wdata,
    input  logic                   ext_start_pin,
    input  logic                   cmp_in,
    input  logic                   pwr_save,
    output logic [CH_BITS+4:0]     ctrl_rd,
    output logic [RES_BITS-3:0]    result_hi,
    output logic [CH_BITS-1:0]     chan_sel,
    output logic                   sample_en,
    output logic [RES_BITS-1:0]    dac_code
);
    localparam int MAX_A   = (INIT_CYC > SAMP_CYC) ? INIT_CYC : SAMP_CYC;
    localparam int MAX_CYC = (MAX_A > BIT_CYC) ? MAX_A : BIT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int B_BUSY  = CH_BITS + POS_BUSY - 3;
    localparam int B_DONE  = CH_BITS + POS_DONE - 3;
    localparam int B_EXT   = CH_BITS + POS_EXT - 3;

    seq_state_e state_q, state_d;

    logic                busy_q, done_q, ext_en_q;
    logic [CH_BITS-1:0]  chan_q;
    logic [RES_BITS-1:0] result_q;

    logic                ext_rise, sw_start, ext_start, accept;
    logic                t_last, t_clr, abort, step, finish;
    logic [CNT_W-1:0]    t_limit;
    logic [RES_BITS-1:0] trial, resolved;
    logic                last_bit;

    sar_seq_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (mc_tick),
        .pin   (ext_start_pin),
        .rise  (ext_rise)
    );

    sar_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (t_clr),
        .tick  (mc_tick),
        .limit (t_limit),
        .last  (t_last)
    );

    sar_seq_sar #(.RES(RES_BITS)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .step     (step),
        .cmp      (cmp_in),
        .trial    (trial),
        .resolved (resolved),
        .last_bit (last_bit)
    );

    // Start qualification
    assign sw_start  = reg_wr & reg_wdata[B_BUSY] & ~busy_q
                     & (~done_q | ~reg_wdata[B_DONE]) & ~pwr_save
                     & (state_q == ST_IDLE);
    assign ext_start = ext_rise & ext_en_q & ~busy_q & ~done_q & ~pwr_save
                     & (state_q == ST_IDLE);
    assign accept    = sw_start | ext_start;

    assign abort  = pwr_save & (state_q != ST_IDLE);
    assign step   = (state_q == ST_RESOLVE) & mc_tick & t_last;
    assign finish = step & last_bit & ~pwr_save;

    always_comb begin
        unique case (state_q)
            ST_INIT:    t_limit = CNT_W'(INIT_CYC);
            ST_SAMPLE:  t_limit = CNT_W'(SAMP_CYC);
            ST_RESOLVE: t_limit = CNT_W'(BIT_CYC);
            default:    t_limit = CNT_W'(1);
        endcase
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = mc_tick ? ST_INIT : ST_ARM;
                end
            end
            ST_ARM: begin
                if (mc_tick) begin
                    state_d = ST_INIT;
                end
            end
            ST_INIT: begin
                if (mc_tick && t_last) begin
                    state_d = ST_SAMPLE;
                end
            end
            ST_SAMPLE: begin
                if (mc_tick && t_last) begin
                    state_d = ST_RESOLVE;
                end
            end
            ST_RESOLVE: begin
                if (finish) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort) begin
            state_d = ST_IDLE;
        end
    end

    assign t_clr = (state_d != state_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Flags, channel and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            ext_en_q <= 1'b0;
            chan_q   <= '0;
            result_q <= '0;
        end else begin
            if (abort || finish) begin
                busy_q <= 1'b0;
            end else if (accept) begin
                busy_q <= 1'b1;
            end

            if (finish) begin
                done_q <= 1'b1;
            end else if (reg_wr && !reg_wdata[B_DONE]) begin
                done_q <= 1'b0;
            end

            if (reg_wr) begin
                ext_en_q <= reg_wdata[B_EXT];
                if (!busy_q && !done_q) begin
                    chan_q <= reg_wdata[CH_BITS-1:0];
                end
            end

            if (finish) begin
                result_q <= resolved;
            end
        end
    end

    assign ctrl_rd   = {result_q[1:0], ext_en_q, done_q, busy_q, chan_q};
    assign result_hi = result_q[RES_BITS-1:2];
    assign chan_sel  = chan_q;
    assign sample_en = (state_q == ST_SAMPLE);
    assign dac_code  = (state_q == ST_RESOLVE) ? trial : '0;
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
    parameter int RES_BITS = 10,
    parameter int CH_BITS  = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pwr_save,
    input logic [CH_BITS+4:0]  ctrl_rd,
    input logic [RES_BITS-3:0] result_hi,
    input logic [CH_BITS-1:0]  chan_sel,
    input logic                sample_en
);
    logic busy, done;
    assign busy = ctrl_rd[CH_BITS];
    assign done = ctrl_rd[CH_BITS+1];

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R8

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy)); // R8

    AST_CHAN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || done) |=> $stable(chan_sel)); // R9

    AST_SAMPLE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> busy); // R5

    AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_hi) |-> $rose(done)); // R10

    AST_ABORT_ON_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_save && busy) |=> !busy); // R10
endmodule

bind sar_adc_sequencer sar_seq_checker #(.RES_BITS(RES_BITS), .CH_BITS(CH_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_save  (pwr_save),
    .ctrl_rd   (ctrl_rd),
    .result_hi (result_hi),
    .chan_sel  (chan_sel),
    .sample_en (sample_en)
);

// File: tb/sim_sar_adc_sequencer.sv
module sim_sar_adc_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       ext_start_pin = 1'b0;
    logic       cmp_in;
    logic       pwr_save = 1'b0;
    logic [7:0] ctrl_rd;
    logic [7:0] result_hi;
    logic [2:0] chan_sel;
    logic       sample_en;
    logic [9:0] dac_code;
    logic [9:0] vin = 10'h000;

    int n_chk = 0;
    int n_bad = 0;
    int tcount = 0;
    int samp_ticks = 0;
    int first_trial = -1;
    bit finished = 1'b0;

    // Behavioural comparator: 1 when the input is at or above the trial code
    assign cmp_in = (vin >= dac_code);

    sar_adc_sequencer u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .mc_tick       (mc_tick),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .ext_start_pin (ext_start_pin),
        .cmp_in        (cmp_in),
        .pwr_save      (pwr_save),
        .ctrl_rd       (ctrl_rd),
        .result_hi     (result_hi),
        .chan_sel      (chan_sel),
        .sample_en     (sample_en),
        .dac_code      (dac_code)
    );

    initial forever #10 clk = ~clk;

    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            mc_tick = (ph == 2);
            ph = (ph + 1) % 3;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        if (mc_tick) tcount++;
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        while (mc_tick) step();
        reg_wr = 1'b1;
        reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic run_ticks(input int k);
        int t0;
        t0 = tcount;
        while (tcount - t0 < k) step();
    endtask

    task automatic wait_done();
        bit seen;
        seen = 1'b0;
        samp_ticks = 0;
        first_trial = -1;
        for (int i = 0; i < 1000; i++) begin
            if (ctrl_rd[4]) break;
            if (seen && !sample_en && first_trial < 0) first_trial = int'(dac_code);
            if (sample_en) begin
                seen = 1'b1;
                if (mc_tick) samp_ticks++;
            end
            step();
        end
    endtask

    task automatic t_reset();
        check(ctrl_rd == 8'h00, "R1 ctrl", ctrl_rd, 0);
        check(result_hi == 8'h00, "R1 result_hi", result_hi, 0);
        check(chan_sel == 3'd0 && sample_en == 1'b0 && dac_code == 10'd0,
              "R1 outputs", {chan_sel, sample_en, dac_code}, 0);
    endtask

    task automatic t_sw_conv();
        int t0;
        vin = 10'h2A5;
        wr(8'h05);
        check(chan_sel == 3'd5, "R9 chan write when free", chan_sel, 5);
        t0 = tcount;
        wr(8'h0D);
        check(ctrl_rd[3] == 1'b1, "R3 busy after write", ctrl_rd[3], 1);
        wait_done();
        check(tcount - t0 == 51, "R3 ticks to done", tcount - t0, 51);
        check(samp_ticks == 8, "R5 sampling cycles", samp_ticks, 8);
        check(first_trial == 'h200, "R5 first trial", first_trial, 'h200);
        check(result_hi == 8'hA9, "R2 result_hi", result_hi, 'hA9);
        check(ctrl_rd[7:6] == 2'b01, "R6 result lsbs", ctrl_rd[7:6], 1);
        check(ctrl_rd[3] == 1'b0, "R8 busy cleared at done", ctrl_rd[3], 0);
    endtask

    task automatic t_locked_and_blocked();
        wr(8'h13);
        check(chan_sel == 3'd5, "R9 chan locked while done", chan_sel, 5);
        wr(8'h1B);
        run_ticks(4);
        check(ctrl_rd[3] == 1'b0, "R7 start blocked by done", ctrl_rd[3], 0);
        check(result_hi == 8'hA9, "R7 result unchanged", result_hi, 'hA9);
    endtask

    task automatic t_clear_and_start();
        int t0;
        vin = 10'h0F0;
        t0 = tcount;
        wr(8'h0B);
        check(chan_sel == 3'd5, "R11 same channel", chan_sel, 5);
        check(ctrl_rd[4:3] == 2'b01, "R11 restart flags", ctrl_rd[4:3], 1);
        wait_done();
        check(tcount - t0 == 51, "R11 ticks to done", tcount - t0, 51);
        check({result_hi, ctrl_rd[7:6]} == 10'h0F0, "R6 result",
              {result_hi, ctrl_rd[7:6]}, 'h0F0);
    endtask

    task automatic t_done_rules();
        wr(8'h05);
        check(ctrl_rd[4] == 1'b0, "R8 done cleared by 0", ctrl_rd[4], 0);
        wr(8'h15);
        run_ticks(2);
        check(ctrl_rd[4] == 1'b0, "R8 done not set by sw", ctrl_rd[4], 0);
    endtask

    task automatic t_busy_ignores();
        int t0;
        vin = 10'h3FF;
        t0 = tcount;
        wr(8'h0D);
        run_ticks(20);
        wr(8'h05);
        check(ctrl_rd[3] == 1'b1, "R8 busy not cleared by sw", ctrl_rd[3], 1);
        wr(8'h0D);
        wait_done();
        check(tcount - t0 == 51, "R7 restart ignored while busy", tcount - t0, 51);
        check({result_hi, ctrl_rd[7:6]} == 10'h3FF, "R6 full scale",
              {result_hi, ctrl_rd[7:6]}, 'h3FF);
        wr(8'h05);
    endtask

    task automatic t_ext_disabled();
        while (mc_tick) step();
        ext_start_pin = 1'b1;
        run_ticks(6);
        check(ctrl_rd[3] == 1'b0, "R4 pin ignored when disabled", ctrl_rd[3], 0);
        ext_start_pin = 1'b0;
        run_ticks(3);
    endtask

    task automatic t_ext_enabled();
        int t0;
        vin = 10'h000;
        wr(8'h25);
        check(ctrl_rd[5] == 1'b1, "R2 ext enable bit", ctrl_rd[5], 1);
        run_ticks(2);
        while (mc_tick) step();
        ext_start_pin = 1'b1;
        t0 = tcount;
        wait_done();
        check(tcount - t0 == 51, "R4 ticks to done", tcount - t0, 51);
        check({result_hi, ctrl_rd[7:6]} == 10'h000, "R6 zero input",
              {result_hi, ctrl_rd[7:6]}, 0);
        ext_start_pin = 1'b0;
        run_ticks(2);
        while (mc_tick) step();
        ext_start_pin = 1'b1;
        run_ticks(3);
        check(ctrl_rd[3] == 1'b0, "R7 pin blocked by done", ctrl_rd[3], 0);
        ext_start_pin = 1'b0;
        wr(8'h05);
        run_ticks(2);
    endtask

    task automatic t_abort();
        vin = 10'h155;
        wr(8'h0D);
        run_ticks(15);
        pwr_save = 1'b1;
        step();
        check(ctrl_rd[4:3] == 2'b00, "R10 abort flags", ctrl_rd[4:3], 0);
        check(result_hi == 8'h00, "R10 result kept on abort", result_hi, 0);
        wr(8'h0D);
        run_ticks(2);
        check(ctrl_rd[3] == 1'b0, "R7 start blocked in power save", ctrl_rd[3], 0);
        pwr_save = 1'b0;
        run_ticks(2);
        wr(8'h0D);
        wait_done();
        check({result_hi, ctrl_rd[7:6]} == 10'h155, "R6 result after abort",
              {result_hi, ctrl_rd[7:6]}, 'h155);
        pwr_save = 1'b1;
        run_ticks(10);
        check(ctrl_rd[4] == 1'b1 && result_hi == 8'h55, "R10 done held in power save",
              {ctrl_rd[4], result_hi}, 'h155);
        pwr_save = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        step();
        t_sw_conv();
        t_locked_and_blocked();
        t_clear_and_start();
        t_done_rules();
        t_busy_ignores();
        t_ext_disabled();
        t_ext_enabled();
        t_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule